// File: doc/BRIEF.md
# Flash-to-memory DMA engine

This block copies a contiguous run of 32-bit words out of the serial-flash read window into system memory. Software programs three registers: a flash source byte address, a memory destination byte address and a byte count. It then moves the enable bit of the control register from 0 to 1. The engine reads one word at a time on a simple flash read port. It forwards each word on a memory write port and advances both addresses by four bytes after every word.

The byte count is rounded up to whole words. When the last write has been accepted, a sticky completion flag rises in the status register. Software clears the flag by writing a one to that bit. The register port is a single-cycle write strobe with a combinational read-back mux. Only one flash read is ever in flight. A new read is issued only once the previous word has been accepted by memory.

Top module: `flash_copy_dma`

## Requirements
- R1: After reset, every register reads 0, the completion flag is clear, and neither `fl_req` nor `mem_wvalid` is asserted.
- R2: The register map is as follows, with unused bits reading 0:
  - control at byte offset 0x80, with the enable in bit 0
  - source address at 0x84
  - destination address at 0x88
  - byte count at 0x8C, lower LEN_W bits
  - status at 0x08, with the completion flag in bit 11

  Each written value reads back unchanged.
- R3: A transfer starts only when a control write takes the stored enable bit from 0 to 1. Writing 1 while the enable already holds 1 starts nothing.
- R4: A transfer moves ceil(count/4) words. Word k is read from source+4k and written, unchanged, to destination+4k, in increasing k.
- R5: Starting a transfer clears the completion flag, so status bit 11 reads 0 while words remain. The flag is set when the final memory write is accepted.
- R6: Writing status with bit 11 = 1 clears the flag. Writing bit 11 = 0 leaves it unchanged.
- R7: A byte count of 0 sets the completion flag on the start edge itself, with no flash read and no memory write.
- R8: While a transfer runs, writes to the source, destination and count registers are ignored and do not affect the transfer.
- R9: At most one flash read is outstanding, and no read is requested while a memory write is pending. A request holds its address, and a write holds its address and data, until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read-back of the register at cfg_addr |
| fl_req | output | 1 | Flash word read request |
| fl_addr | output | ADDR_W | Flash word byte address |
| fl_ready | input | 1 | Flash accepts the request this cycle |
| fl_rvalid | input | 1 | Flash read data valid |
| fl_rdata | input | 32 | Flash read data |
| mem_wvalid | output | 1 | Memory write valid |
| mem_waddr | output | ADDR_W | Memory write byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_wready | input | 1 | Memory accepts the write this cycle |

## Verification
A wrong word counter shows up at the ports as a wrong number of memory writes before status bit 11 rises. It becomes visible within one word time of the expected last write. A pointer that steps wrongly shows on the very next write address or data, which the bench compares against a computed pattern word by word. A sequencer that loses track of its outstanding read asserts `fl_req` while a response or a write is still pending, which is caught in the same cycle. A flag or enable register holding a stale value shows on the next status read, or as a transfer that starts or fails to start.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int DATA_W   = 32;
  localparam int REG_AW   = 8;
  localparam int DONE_BIT = 11;

  localparam logic [REG_AW-1:0] OFS_STATUS = 8'h08;
  localparam logic [REG_AW-1:0] OFS_CTRL   = 8'h80;
  localparam logic [REG_AW-1:0] OFS_SRC    = 8'h84;
  localparam logic [REG_AW-1:0] OFS_DST    = 8'h88;
  localparam logic [REG_AW-1:0] OFS_LEN    = 8'h8C;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_REQ  = 2'd1,
    ST_RD_WAIT = 2'd2,
    ST_WR      = 2'd3
  } seq_state_e;

endpackage

// File: rtl/fcd_ptr.sv
module fcd_ptr #(
  parameter int W    = 32,
  parameter int STEP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] ptr
);

  logic [W-1:0] ptr_q;
  logic [W-1:0] ptr_d;
  logic         ptr_en;

  always_comb begin
    ptr_en = load | step;
    if (load) ptr_d = load_val;
    else      ptr_d = ptr_q + W'(STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/fcd_regs.sv
module fcd_regs
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              busy_i,
  input  logic              done_set_i,
  output logic              start_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [LEN_W-1:0]  len_o
);

  logic              en_q, en_d;
  logic              done_q, done_d;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  len_q;
  logic              hit_stat, hit_ctrl, hit_src, hit_dst, hit_len;
  logic              src_en, dst_en, len_en;

  // address decode and write enables
  always_comb begin
    hit_stat = cfg_we && (cfg_addr == OFS_STATUS);
    hit_ctrl = cfg_we && (cfg_addr == OFS_CTRL);
    hit_src  = cfg_we && (cfg_addr == OFS_SRC);
    hit_dst  = cfg_we && (cfg_addr == OFS_DST);
    hit_len  = cfg_we && (cfg_addr == OFS_LEN);
    src_en   = hit_src && !busy_i;
    dst_en   = hit_dst && !busy_i;
    len_en   = hit_len && !busy_i;
  end

  // start on a rising enable, completion flag next state
  always_comb begin
    en_d    = hit_ctrl ? cfg_wdata[0] : en_q;
    start_o = hit_ctrl && cfg_wdata[0] && !en_q && !busy_i;
    if (done_set_i)                           done_d = 1'b1;
    else if (start_o)                         done_d = 1'b0;
    else if (hit_stat && cfg_wdata[DONE_BIT]) done_d = 1'b0;
    else                                      done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_q <= '0;
    else if (src_en) src_q <= cfg_wdata[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dst_q <= '0;
    else if (dst_en) dst_q <= cfg_wdata[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_en) len_q <= cfg_wdata[LEN_W-1:0];
  end

  // read-back mux
  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_addr)
      OFS_STATUS: cfg_rdata[DONE_BIT] = done_q;
      OFS_CTRL:   cfg_rdata[0]        = en_q;
      OFS_SRC:    cfg_rdata           = DATA_W'(src_q);
      OFS_DST:    cfg_rdata           = DATA_W'(dst_q);
      OFS_LEN:    cfg_rdata           = DATA_W'(len_q);
      default:    cfg_rdata           = '0;
    endcase
  end

  assign src_o = src_q;
  assign dst_o = dst_q;
  assign len_o = len_q;

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  output logic              fl_req,
  output logic [ADDR_W-1:0] fl_addr,
  input  logic              fl_ready,
  input  logic              fl_rvalid,
  input  logic [DATA_W-1:0] fl_rdata,
  output logic              mem_wvalid,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_wready,
  output logic              busy,
  output logic              xfer_done
);

  localparam int CNT_W = LEN_W - 1;

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  remain_q, remain_d, words;
  logic [DATA_W-1:0] data_q;
  logic              data_en, remain_en;
  logic              rd_acc, wr_acc, last_word;

  assign words = CNT_W'(({1'b0, len} + 3) >> 2);

  always_comb begin
    rd_acc    = (state_q == ST_RD_REQ) && fl_ready;
    wr_acc    = (state_q == ST_WR) && mem_wready;
    last_word = (remain_q == CNT_W'(1));
    data_en   = (state_q == ST_RD_WAIT) && fl_rvalid;
  end

  // next-state logic
  always_comb begin
    state_d   = state_q;
    remain_d  = remain_q;
    remain_en = 1'b0;
    xfer_done = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          remain_d  = words;
          remain_en = 1'b1;
          if (words == '0) xfer_done = 1'b1;
          else             state_d   = ST_RD_REQ;
        end
      end
      ST_RD_REQ:  if (fl_ready)  state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (fl_rvalid) state_d = ST_WR;
      ST_WR: begin
        if (mem_wready) begin
          remain_d  = remain_q - CNT_W'(1);
          remain_en = 1'b1;
          if (last_word) begin
            state_d   = ST_IDLE;
            xfer_done = 1'b1;
          end else begin
            state_d   = ST_RD_REQ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         remain_q <= '0;
    else if (remain_en) remain_q <= remain_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= fl_rdata;
  end

  fcd_ptr #(.W(ADDR_W), .STEP(4)) u_src_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start && (state_q == ST_IDLE)),
    .load_val (src),
    .step     (rd_acc),
    .ptr      (fl_addr)
  );

  fcd_ptr #(.W(ADDR_W), .STEP(4)) u_dst_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start && (state_q == ST_IDLE)),
    .load_val (dst),
    .step     (wr_acc),
    .ptr      (mem_waddr)
  );

  assign fl_req     = (state_q == ST_RD_REQ);
  assign mem_wvalid = (state_q == ST_WR);
  assign mem_wdata  = data_q;
  assign busy       = (state_q != ST_IDLE);

endmodule

// File: rtl/flash_copy_dma.sv
module flash_copy_dma
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              fl_req,
  output logic [ADDR_W-1:0] fl_addr,
  input  logic              fl_ready,
  input  logic              fl_rvalid,
  input  logic [31:0]       fl_rdata,
  output logic              mem_wvalid,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_wready
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              start;
  logic              busy;
  logic              xfer_done;
  logic [ADDR_W-1:0] src_cfg;
  logic [ADDR_W-1:0] dst_cfg;
  logic [LEN_W-1:0]  len_cfg;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  fcd_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .busy_i     (busy),
    .done_set_i (xfer_done),
    .start_o    (start),
    .src_o      (src_cfg),
    .dst_o      (dst_cfg),
    .len_o      (len_cfg)
  );

  fcd_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start      (start),
    .len        (len_cfg),
    .src        (src_cfg),
    .dst        (dst_cfg),
    .fl_req     (fl_req),
    .fl_addr    (fl_addr),
    .fl_ready   (fl_ready),
    .fl_rvalid  (fl_rvalid),
    .fl_rdata   (fl_rdata),
    .mem_wvalid (mem_wvalid),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .mem_wready (mem_wready),
    .busy       (busy),
    .xfer_done  (xfer_done)
  );

endmodule

// File: rtl/fcd_chk.sv
module fcd_chk
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [7:0]        cfg_addr,
  input logic              start,
  input logic              busy,
  input logic              xfer_done,
  input logic [ADDR_W-1:0] src_cfg,
  input logic [LEN_W-1:0]  len_cfg,
  input logic              fl_req,
  input logic [ADDR_W-1:0] fl_addr,
  input logic              fl_ready,
  input logic              fl_rvalid,
  input logic              mem_wvalid,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic [31:0]       mem_wdata,
  input logic              mem_wready
);

  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend_q <= 1'b0;
    else if (fl_req && fl_ready) pend_q <= 1'b1;
    else if (fl_rvalid)        pend_q <= 1'b0;
  end

  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !fl_req);

  a_r9_no_read_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> !fl_req);

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && !fl_ready) |=> (fl_req && $stable(fl_addr)));

  a_r9_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));

  a_r8_src_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we && (cfg_addr == OFS_SRC)) |=> $stable(src_cfg));

  a_r7_zero_len_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (len_cfg == '0)) |=> (!busy && !fl_req));

  a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !busy);

endmodule

bind flash_copy_dma fcd_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .start      (start),
  .busy       (busy),
  .xfer_done  (xfer_done),
  .src_cfg    (src_cfg),
  .len_cfg    (len_cfg),
  .fl_req     (fl_req),
  .fl_addr    (fl_addr),
  .fl_ready   (fl_ready),
  .fl_rvalid  (fl_rvalid),
  .mem_wvalid (mem_wvalid),
  .mem_waddr  (mem_waddr),
  .mem_wdata  (mem_wdata),
  .mem_wready (mem_wready)
);

// File: tb/flash_copy_dma_tb.sv
`timescale 1ns/1ps
module flash_copy_dma_tb;

  localparam logic [7:0] A_STAT = 8'h08;
  localparam logic [7:0] A_CTRL = 8'h80;
  localparam logic [7:0] A_SRC  = 8'h84;
  localparam logic [7:0] A_DST  = 8'h88;
  localparam logic [7:0] A_LEN  = 8'h8C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        fl_req, fl_ready, fl_rvalid;
  logic [31:0] fl_addr, fl_rdata;
  logic        mem_wvalid, mem_wready;
  logic [31:0] mem_waddr, mem_wdata;

  int checks = 0;
  int errors = 0;
  int rd_lat = 0, rd_gap = 0, wr_gap = 0;
  int wcount = 0, wr_bad = 0, ov_bad = 0;
  logic [31:0] exp_src = 0, exp_dst = 0;

  always #4 clk = ~clk;

  flash_copy_dma u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fl_req(fl_req),
    .fl_addr(fl_addr), .fl_ready(fl_ready), .fl_rvalid(fl_rvalid),
    .fl_rdata(fl_rdata), .mem_wvalid(mem_wvalid), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .mem_wready(mem_wready)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {~a[15:0], a[15:0]} ^ 32'h0F1E_2D3C;
  endfunction

  // flash responder
  initial begin
    logic        s_req, s_rdy, pend;
    logic [31:0] s_addr, paddr;
    int          lat, tick;
    s_req = 0; s_rdy = 0; pend = 0; s_addr = 0; paddr = 0; lat = 0; tick = 0;
    fl_ready = 0; fl_rvalid = 0; fl_rdata = 0;
    forever begin
      @(negedge clk);
      fl_rvalid = 1'b0;
      if (s_req && s_rdy) begin
        if (pend) ov_bad++;
        pend = 1; paddr = s_addr; lat = rd_lat;
      end
      if (pend) begin
        if (lat == 0) begin fl_rvalid = 1'b1; fl_rdata = pat(paddr); pend = 0; end
        else lat--;
      end
      tick++;
      fl_ready = (rd_gap == 0) || (tick % (rd_gap + 1) == 0);
      if (fl_req && mem_wvalid) ov_bad++;
      s_req = fl_req; s_rdy = fl_ready; s_addr = fl_addr;
    end
  end

  // memory sink
  initial begin
    logic        s_v, s_r;
    logic [31:0] s_a, s_d;
    int          tick;
    s_v = 0; s_r = 0; s_a = 0; s_d = 0; tick = 0;
    mem_wready = 0;
    forever begin
      @(negedge clk);
      if (s_v && s_r) begin
        if (s_a != exp_dst + 32'(4 * wcount) || s_d != pat(exp_src + 32'(4 * wcount))) wr_bad++;
        wcount++;
      end
      tick++;
      mem_wready = (wr_gap == 0) || (tick % (wr_gap + 1) == 1);
      s_v = mem_wvalid; s_r = mem_wready; s_a = mem_waddr; s_d = mem_wdata;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic launch(input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
    cfg_wr(A_CTRL, 0); cfg_wr(A_SRC, s); cfg_wr(A_DST, d); cfg_wr(A_LEN, n);
    exp_src = s; exp_dst = d; wcount = 0; wr_bad = 0;
    cfg_wr(A_CTRL, 1);
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 600; i++) begin
      cfg_rd(A_STAT, v);
      if (v[11]) begin ok = 1; return; end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    cfg_rd(A_STAT, v); check(v == 0, "R1 status", v, 0);
    cfg_rd(A_CTRL, v); check(v == 0, "R1 ctrl", v, 0);
    cfg_rd(A_SRC, v);  check(v == 0, "R1 src", v, 0);
    cfg_rd(A_LEN, v);  check(v == 0, "R1 len", v, 0);
    check(!fl_req && !mem_wvalid, "R1 ports idle", {fl_req, mem_wvalid}, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    cfg_wr(A_SRC, 32'h1234_5670); cfg_rd(A_SRC, v); check(v == 32'h1234_5670, "R2 src", v, 32'h1234_5670);
    cfg_wr(A_DST, 32'hCAFE_0040); cfg_rd(A_DST, v); check(v == 32'hCAFE_0040, "R2 dst", v, 32'hCAFE_0040);
    cfg_wr(A_LEN, 32'h0001_00FF); cfg_rd(A_LEN, v); check(v == 32'h0000_00FF, "R2 len", v, 32'h0000_00FF);
  endtask

  task automatic t_basic;
    bit ok; logic [31:0] v;
    launch(32'h0000_4000, 32'h8000_0100, 16);
    wait_done(ok); check(ok, "R5 done set", ok, 1);
    check(wcount == 4, "R4 word count 16B", wcount, 4);
    check(wr_bad == 0, "R4 addr/data", wr_bad, 0);
    cfg_rd(A_CTRL, v); check(v == 1, "R2 ctrl enable", v, 1);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    cfg_wr(A_STAT, 32'hFFFF_F7FF); cfg_rd(A_STAT, v); check(v == 32'h800, "R6 zero keeps flag", v, 32'h800);
    cfg_wr(A_STAT, 32'h800);       cfg_rd(A_STAT, v); check(v == 0, "R6 w1c clears", v, 0);
  endtask

  task automatic t_round;
    bit ok;
    launch(32'h0000_0200, 32'h0000_9000, 10);
    wait_done(ok); check(ok && wcount == 3, "R4 len 10 -> 3 words", wcount, 3);
    check(wr_bad == 0, "R4 data len 10", wr_bad, 0);
    cfg_wr(A_STAT, 32'h800);
    launch(32'h0000_0300, 32'h0000_A000, 1);
    wait_done(ok); check(ok && wcount == 1, "R4 len 1 -> 1 word", wcount, 1);
    cfg_wr(A_STAT, 32'h800);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    launch(32'h0000_1000, 32'h0000_2000, 0);
    cfg_rd(A_STAT, v); check(v == 32'h800, "R7 zero len done at once", v, 32'h800);
    idle(20); check(wcount == 0, "R7 no writes", wcount, 0);
    cfg_wr(A_STAT, 32'h800);
  endtask

  task automatic t_stall;
    bit ok; logic [31:0] v;
    rd_lat = 3; rd_gap = 2; wr_gap = 2;
    launch(32'h0001_0000, 32'h0002_0000, 24);
    cfg_rd(A_STAT, v); check(v == 0, "R5 busy reads 0", v, 0);
    cfg_wr(A_SRC, 32'hDEAD_0000); cfg_rd(A_SRC, v);
    check(v == 32'h0001_0000, "R8 src write ignored", v, 32'h0001_0000);
    cfg_wr(A_LEN, 32'h40); cfg_rd(A_LEN, v); check(v == 24, "R8 len write ignored", v, 24);
    wait_done(ok); check(ok && wcount == 6, "R8 six words moved", wcount, 6);
    check(wr_bad == 0, "R4 stalled data", wr_bad, 0);
    check(ov_bad == 0, "R9 one outstanding", ov_bad, 0);
    rd_lat = 0; rd_gap = 0; wr_gap = 0;
    cfg_wr(A_STAT, 32'h800);
  endtask

  task automatic t_restart;
    bit ok; logic [31:0] v;
    wcount = 0;
    cfg_wr(A_CTRL, 1); idle(30);
    check(wcount == 0, "R3 rewrite of 1 no start", wcount, 0);
    cfg_rd(A_STAT, v); check(v == 0, "R3 no flag", v, 0);
    cfg_wr(A_CTRL, 0); cfg_wr(A_CTRL, 1);
    wait_done(ok); check(ok && wcount == 6, "R3 0->1 starts", wcount, 6);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 0; cfg_wdata = 0;
    idle(4); rst_n = 1'b1; idle(4);
    t_reset;
    t_regmap;
    t_basic;
    t_clear;
    t_round;
    t_zero;
    t_stall;
    t_restart;
    check(ov_bad == 0, "R9 final", ov_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule